// File: doc/BRIEF.md
# Dual-Output Compare-Match PWM Timer

This block is a single timer channel that generates up to two pulse-width-modulated outputs from one 16-bit up-counter. The counter advances on a prescaled tick whose division ratio (1, 4, 16 or 64) is a power of four and is common to both outputs. Four 16-bit general registers form two period/duty pairs. Pair 0 uses GRA as its period and GRB as its duty. Pair 1 uses GRC as its period and GRD as its duty. A control field chooses whether the counter returns to zero after matching GRA or after matching GRC.

Software programs the channel through a flat write port and reads any register back through a combinational read port. A typical sequence is:
1. Stop the counter.
2. Program the control word, the period/duty values and the counter start value.
3. Select PWM mode 1 in the mode register.
4. Write the PWM code into the I/O-control byte of each output that should drive.
5. Set the run bit.

While the PWM code is not selected, an output's enable stays low, so the pin floats.

Register map (word addresses):

| Address | Register | Contents |
|---------|----------|----------|
| 0 | control | bits [1:0] division select n, bit 2 clear source (0 = GRA, 1 = GRC) |
| 1 | run | bit 0 |
| 2 | mode | PWM mode 1 = 8'h02 |
| 3 | I/O-control, output 0 | PWM code = 8'h12, float/retain = 8'h00 |
| 4 | I/O-control, output 1 | same codes as output 0 |
| 5 to 8 | GRA, GRB, GRC, GRD | 16-bit period/duty values |
| 9 | counter | writable only while stopped |

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset every register, including the counter, reads zero, the run bit is clear, both pin_oe bits are 0 and both pin_out bits are 0.
- R2: While running, the counter advances once every 4^n clock cycles, where n is the division select in control bits [1:0].
- R3: While stopped, the counter keeps its value.
- R4: On a tick where the counter equals the clear-source register (control bit 2: 0 selects GRA at address 5, 1 selects GRC at address 7), the counter goes to 0 on that tick instead of incrementing. The resulting period is (P+1)·4^n clock cycles.
- R5: For an output driving in PWM mode with duty D below period P, the pin is set high on the period match and toggles on the duty match. In steady state the pin is therefore high exactly while the counter value is ≤ D.
- R6: When the duty value is greater than or equal to the period value, the pin stays high for the whole period. If both matches occur on the same tick, the period match wins.
- R7: A write to the control register (address 0) while the run bit is set is ignored, and the old value reads back. The counter (address 9) is likewise writable only while stopped.
- R8: An output's pin_oe is 1 only when its I/O-control byte holds 8'h12 and the mode register holds 8'h02. Otherwise pin_oe is 0 and that pin_out keeps its value.
- R9: Each register at addresses 0 to 9 reads back, zero-extended, the value last written to it. Address 9 returns the live counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Combinational read data |
| pin_out | output | 2 | PWM output levels |
| pin_oe | output | 2 | Output enables (0 = high impedance) |

## Verification
The condition hardest to reach from the ports is a clean steady-state waveform. Before the first period match, the toggle-on-duty rule can leave the pin at either level. The bench therefore checks the pin against the expected level only after it has seen the counter wrap once through the normal read port. It then compares every clock of the following period against the counter value read in the same cycle. The bench sweeps every division select against several period values and every duty from 0 up to one past the period. This covers the case where the duty match and the period match coincide, and the case where the duty match is never reached.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_CTL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_RUN  = 4'd1;
   localparam logic [ADDR_W-1:0] A_MODE = 4'd2;
   localparam logic [ADDR_W-1:0] A_IO0  = 4'd3;
   localparam logic [ADDR_W-1:0] A_IO1  = 4'd4;
   localparam logic [ADDR_W-1:0] A_GRA  = 4'd5;
   localparam logic [ADDR_W-1:0] A_CNT  = 4'd9;
   localparam logic [7:0] MODE_PWM1 = 8'h02;
   localparam logic [7:0] IO_PWM    = 8'h12;

   typedef struct packed {
      logic       clr_c;
      logic [1:0] div_sel;
   } ctl_t;
endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
   import pwmt_pkg::*;
#(
   parameter int DW     = 16,
   parameter int N_GR   = 4,
   parameter int N_OUT  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic [ADDR_W-1:0]        rd_addr,
   input  logic [DW-1:0]            cnt,
   output logic [DW-1:0]            rd_data,
   output ctl_t                     ctl,
   output logic                     run,
   output logic [7:0]               mode,
   output logic [N_OUT-1:0][7:0]    io,
   output logic [N_GR-1:0][DW-1:0]  gr,
   output logic                     cnt_load
);
   localparam int CTL_W = $bits(ctl_t);

   assign cnt_load = wr_en && (wr_addr == A_CNT) && !run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl  <= '0;
         run  <= 1'b0;
         mode <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTL && !run) ctl <= ctl_t'(wr_data[CTL_W-1:0]);
         if (wr_addr == A_RUN) run  <= wr_data[0];
         if (wr_addr == A_MODE) mode <= wr_data[7:0];
      end
   end

   for (genvar i = 0; i < N_OUT; i++) begin : g_io
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) io[i] <= '0;
         else if (wr_en && wr_addr == A_IO0 + ADDR_W'(i)) io[i] <= wr_data[7:0];
      end
   end

   for (genvar g = 0; g < N_GR; g++) begin : g_gr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) gr[g] <= '0;
         else if (wr_en && wr_addr == A_GRA + ADDR_W'(g)) gr[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTL) rd_data = DW'(ctl);
      else if (rd_addr == A_RUN) rd_data = DW'(run);
      else if (rd_addr == A_MODE) rd_data = DW'(mode);
      else if (rd_addr == A_CNT) rd_data = cnt;
      for (int i = 0; i < N_OUT; i++)
         if (rd_addr == A_IO0 + ADDR_W'(i)) rd_data = DW'(io[i]);
      for (int g = 0; g < N_GR; g++)
         if (rd_addr == A_GRA + ADDR_W'(g)) rd_data = gr[g];
   end
endmodule

// File: rtl/pwmt_prescale.sv
module pwmt_prescale #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PW = 2 * ((1 << SEL_W) - 1);

   if (PW == 0) begin : g_nodiv
      assign tick = run;
   end else begin : g_div
      logic [PW-1:0] pcnt;
      logic [PW-1:0] lim;
      assign lim  = PW'((1 << (2 * sel)) - 1);
      assign tick = run && (pcnt == lim);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pcnt <= '0;
         else if (!run || tick) pcnt <= '0;
         else pcnt <= pcnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [DW-1:0] clr_val,
   input  logic          load,
   input  logic [DW-1:0] load_val,
   output logic [DW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else if (load) cnt <= load_val;
      else if (tick) cnt <= (cnt == clr_val) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/pwmt_outunit.sv
module pwmt_outunit #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          active,
   input  logic [DW-1:0] cnt,
   input  logic [DW-1:0] per,
   input  logic [DW-1:0] duty,
   output logic          lvl
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl <= 1'b0;
      else if (tick && active) begin
         if (cnt == per) lvl <= 1'b1;
         else if (cnt == duty) lvl <= ~lvl;
      end
   end
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
   import pwmt_pkg::*;
#(
   parameter int DW    = 16,
   parameter int SEL_W = 2,
   parameter int N_OUT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic [N_OUT-1:0]  pin_out,
   output logic [N_OUT-1:0]  pin_oe
);
   localparam int N_GR = 2 * N_OUT;

   if (DW < 8 || SEL_W != 2 || N_OUT != 2) begin : g_bad_cfg
      initial $fatal(1, "pwm_pair_timer: unsupported parameter set");
   end

   ctl_t                    ctl;
   logic                    run;
   logic [7:0]              mode;
   logic [N_OUT-1:0][7:0]   io;
   logic [N_GR-1:0][DW-1:0] gr;
   logic                    cnt_load;
   logic [DW-1:0]           cnt;
   logic [DW-1:0]           clr_val;
   logic                    tick;
   logic [N_OUT-1:0]        act;

   pwmt_regs #(.DW(DW), .N_GR(N_GR), .N_OUT(N_OUT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .cnt(cnt), .rd_data(rd_data),
      .ctl(ctl), .run(run), .mode(mode), .io(io), .gr(gr),
      .cnt_load(cnt_load)
   );

   pwmt_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .sel(ctl.div_sel), .tick(tick)
   );

   assign clr_val = ctl.clr_c ? gr[2] : gr[0];

   pwmt_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr_val(clr_val),
      .load(cnt_load), .load_val(wr_data), .cnt(cnt)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      assign act[i]    = (mode == MODE_PWM1) && (io[i] == IO_PWM);
      assign pin_oe[i] = act[i];
      pwmt_outunit #(.DW(DW)) u_ou (
         .clk(clk), .rst_n(rst_n), .tick(tick), .active(act[i]),
         .cnt(cnt), .per(gr[2*i]), .duty(gr[2*i+1]), .lvl(pin_out[i])
      );
   end
endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          run,
   input logic [DW-1:0] cnt,
   input logic [DW-1:0] clr_val,
   input logic          load,
   input logic [2:0]    ctl_bits,
   input logic [DW-1:0] per0,
   input logic          act0,
   input logic          out0
);
   a_r2_tick_only_running: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run);
   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt));
   a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == clr_val) |=> (cnt == '0));
   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt != clr_val) |=> (cnt == $past(cnt) + 1'b1));
   a_r7_ctl_locked: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(ctl_bits));
   a_r5_set_on_period: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && act0 && cnt == per0) |=> out0);
endmodule

bind pwm_pair_timer pwmt_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cnt(cnt),
   .clr_val(clr_val), .load(cnt_load), .ctl_bits(ctl), .per0(gr[0]),
   .act0(act[0]), .out0(pin_out[0])
);

// File: tb/pwm_pair_timer_tb.sv
`timescale 1ns/1ps
module pwm_pair_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [1:0]  pin_out, pin_oe;
   int total = 0, bad = 0;

   localparam logic [15:0] PWM1 = 16'h0002, IOPWM = 16'h0012;

   pwm_pair_timer u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_out(pin_out), .pin_oe(pin_oe));

   always #10 clk = ~clk;

   initial begin
      #(20 * 190000);
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] v);
      rd_addr = a; #1 v = rd_data;
   endtask

   // waits for counter wrap; optionally compares pin idx every sample
   task automatic wait_wrap(input bit chk, input int idx, input int per, input int duty,
                            output int clocks, output int errs, output int first_bad);
      logic [15:0] prev, cur;
      bit exp;
      rd_addr = 4'd9; #1 prev = rd_data;
      clocks = 0; errs = 0; first_bad = -1;
      for (int k = 0; k < 6000; k++) begin
         @(negedge clk); #1;
         clocks++;
         cur = rd_data;
         exp = (duty >= per) ? 1'b1 : (int'(cur) <= duty);
         if (chk && pin_out[idx] !== exp) begin
            errs++;
            if (first_bad < 0) first_bad = int'(pin_out[idx]);
         end
         if (cur == 0 && prev != 0) break;
         prev = cur;
      end
   endtask

   initial begin
      logic [15:0] v, v2;
      int clk_n, errs, fb, per;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(pin_oe == 2'b00, "R1 pin_oe", pin_oe, 0);
      check(pin_out == 2'b00, "R1 pin_out", pin_out, 0);
      for (int a = 0; a < 10; a++) begin
         rd(4'(a), v);
         check(v == 0, $sformatf("R1 reg %0d", a), v, 0);
      end

      // R9: readback
      for (int a = 5; a < 9; a++) wr(4'(a), 16'(16'h1111 * a));
      for (int a = 5; a < 9; a++) begin
         rd(4'(a), v);
         check(v == 16'(16'h1111 * a), "R9 general register", v, 16'h1111 * a);
      end
      wr(4'd0, 16'hFFFF); rd(4'd0, v);
      check(v == 16'h0007, "R9 control", v, 7);
      wr(4'd9, 16'h1234); rd(4'd9, v);
      check(v == 16'h1234, "R9 counter", v, 16'h1234);
      wr(4'd3, 16'h00A5); rd(4'd3, v);
      check(v == 16'h00A5, "R9 io0", v, 16'hA5);

      // R8: output floats unless mode and io code both select PWM
      wr(4'd0, 16'd0); wr(4'd5, 16'd3); wr(4'd6, 16'd1); wr(4'd9, 16'd0);
      wr(4'd3, 16'd0); wr(4'd2, PWM1); wr(4'd1, 16'd1);
      v2 = 16'(pin_out[0]);
      repeat (40) @(negedge clk);
      check(pin_oe[0] == 1'b0, "R8 oe with io off", pin_oe[0], 0);
      check(16'(pin_out[0]) == v2, "R8 level held with io off", pin_out[0], v2);
      wr(4'd2, 16'd0); wr(4'd3, IOPWM);
      repeat (10) @(negedge clk);
      check(pin_oe[0] == 1'b0, "R8 oe with wrong mode", pin_oe[0], 0);
      check(16'(pin_out[0]) == v2, "R8 level held with wrong mode", pin_out[0], v2);
      wr(4'd2, PWM1);
      check(pin_oe[0] == 1'b1, "R8 oe enabled", pin_oe[0], 1);

      // R7: control locked while running
      wr(4'd0, 16'h0003); rd(4'd0, v);
      check(v == 16'h0000, "R7 control write while running", v, 0);
      wr(4'd9, 16'h0077); rd(4'd9, v);
      check(v <= 16'd3, "R7 counter write while running", v, 3);

      // R3: counter holds when stopped
      wr(4'd1, 16'd0); rd(4'd9, v);
      repeat (30) @(negedge clk);
      rd(4'd9, v2);
      check(v == v2, "R3 counter stopped", v2, v);

      // R2 R4 R5 R6 sweep on output 0 (clear on GRA)
      for (int p = 0; p < 4; p++)
         for (int ai = 0; ai < 3; ai++) begin
            per = (ai == 0) ? 1 : (ai == 1) ? 2 : 5;
            for (int d = 0; d <= per + 1; d++) begin
               wr(4'd1, 16'd0); wr(4'd0, 16'(p)); wr(4'd5, 16'(per));
               wr(4'd6, 16'(d)); wr(4'd9, 16'd0); wr(4'd1, 16'd1);
               wait_wrap(1'b0, 0, per, d, clk_n, errs, fb);
               wait_wrap(1'b1, 0, per, d, clk_n, errs, fb);
               check(clk_n == (per + 1) << (2 * p), "R2 R4 period length",
                     clk_n, (per + 1) << (2 * p));
               if (d >= per)
                  check(errs == 0, "R6 pin stays high", fb, 1);
               else
                  check(errs == 0, "R5 pin waveform", fb, -1);
            end
         end

      // R4 R5 on output 1 with clear on GRC
      wr(4'd1, 16'd0); wr(4'd0, 16'h0004); wr(4'd7, 16'd3); wr(4'd8, 16'd1);
      wr(4'd4, IOPWM); wr(4'd9, 16'd0); wr(4'd1, 16'd1);
      wait_wrap(1'b0, 1, 3, 1, clk_n, errs, fb);
      wait_wrap(1'b1, 1, 3, 1, clk_n, errs, fb);
      check(clk_n == 4, "R4 clear on GRC", clk_n, 4);
      check(errs == 0, "R5 output 1 waveform", fb, -1);
      check(pin_oe[1] == 1'b1, "R8 oe output 1", pin_oe[1], 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule